// File: doc/BRIEF.md
# Lane Word Synchronization Monitor

This block watches one 8b/10b receive lane after deserialization, comma alignment and decoding have been done upstream. Every accepted character arrives with three status flags (comma seen, code violation, running-disparity error) and a strobe that marks the first character of a transmission word. The block gathers four characters into a word, classifies the word as a violation, an idle ordered set or a plain valid word, and steps a synchronization state machine once per completed word.

From the lost state the lane must see three idle ordered sets, with no violation in between, before word sync is declared. Once locked, each violating word pushes the machine one level further from sync, and two valid words in a row after a violation pull it back one level. A fourth violation that has not been worked off drops the lane to the lost state. Synchronous reset, or deasserting the enable, forces the lost state.

Top module: `fcws_lane_sync`

## Requirements
- R1: While `rst` is 1, or in the cycle after `lsm_en` was 0, `los` is 1 and `word_sync` is 0.
- R2: A word is the four accepted characters (`chr_valid`=1) starting at one with `word_start`=1, positions 0 to 3 in arrival order; cycles with `chr_valid`=0 are ignored, and a `word_start` before position 3 abandons the unfinished word.
- R3: A word is a violation if any of its characters has `chr_cv`=1 or `chr_rderr`=1, or has `chr_comma`=1 at position 1, 2 or 3.
- R4: An idle ordered set is a non-violating word whose position-0 character has `chr_comma`=1.
- R5: From the lost state, three idle ordered sets make `word_sync` 1; `los` goes to 0 after the first one, and non-violating words without a leading comma leave the count unchanged.
- R6: A violating word while not locked returns the machine to the lost state (`los`=1) and restarts the count.
- R7: While locked, every violating word raises the violation level by one and clears the valid-word progress; a violation at level 3 drops the lane to the lost state.
- R8: At a nonzero level, a first valid word after a violation changes nothing visible, and a second consecutive one lowers the level by one; at level 0 valid words change nothing.
- R9: `word_sync` is 1 in every locked level (0 to 3) and 0 otherwise; `los` and `word_sync` are never both 1.
- R10: The outputs reflect a word after the second rising edge counting the one that samples its fourth character, and stay unchanged until then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Lane clock |
| rst | input | 1 | Synchronous active-high reset |
| lsm_en | input | 1 | Enable; 0 forces the lost state |
| chr_valid | input | 1 | A decoded character is present this cycle |
| word_start | input | 1 | Present character is position 0 of a word |
| chr_comma | input | 1 | Character is a comma |
| chr_cv | input | 1 | Character is a code violation |
| chr_rderr | input | 1 | Character has a running-disparity error |
| word_sync | output | 1 | Word synchronization held |
| los | output | 1 | Lane is in the lost state |

## Verification
Each word result is due two rising edges after the edge that samples its fourth character: one edge registers the word summary and the next one updates the state, so the bench drives on falling edges and compares both outputs at the falling edge following the second of those rising edges. One directed case also samples the falling edge in between, where the old outputs must still be present. The enable check samples one falling edge after the single cycle with `lsm_en` low. Random words with random idle gaps are compared against a per-word reference model kept in bench functions.

// File: rtl/fcws_pkg.sv
package fcws_pkg;

    typedef enum logic [1:0] {
        PH_LOST = 2'd0,
        PH_ACQ  = 2'd1,
        PH_LOCK = 2'd2
    } phase_e;

    typedef struct packed {
        logic comma;
        logic cv;
        logic rderr;
    } chr_flags_t;

    typedef struct packed {
        logic viol;
        logic ordset;
    } word_sum_t;

    function automatic logic char_is_bad(input chr_flags_t f, input logic first_pos);
        return f.cv | f.rderr | (f.comma & ~first_pos);
    endfunction

endpackage

// File: rtl/fcws_word_collect.sv
module fcws_word_collect
    import fcws_pkg::*;
#(
    parameter int WORD_CHARS = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  logic       chr_valid,
    input  logic       word_start,
    input  chr_flags_t flags,
    output logic       word_done,
    output word_sum_t  word_sum
);
    localparam int PW = (WORD_CHARS > 2) ? $clog2(WORD_CHARS) : 1;

    logic [PW-1:0] pos;
    logic [PW-1:0] idx;
    logic          acc_viol;
    logic          acc_comma0;
    logic          first_pos;
    logic          last_pos;
    logic          viol_now;
    logic          comma0_now;

    always_comb begin
        idx        = word_start ? '0 : pos;
        first_pos  = (idx == '0);
        last_pos   = (idx == PW'(WORD_CHARS - 1));
        viol_now   = (first_pos ? 1'b0 : acc_viol) | char_is_bad(flags, first_pos);
        comma0_now = first_pos ? flags.comma : acc_comma0;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            pos        <= '0;
            acc_viol   <= 1'b0;
            acc_comma0 <= 1'b0;
            word_done  <= 1'b0;
            word_sum   <= '0;
        end else begin
            word_done <= 1'b0;
            if (chr_valid) begin
                if (last_pos) begin
                    pos             <= '0;
                    acc_viol        <= 1'b0;
                    acc_comma0      <= 1'b0;
                    word_done       <= 1'b1;
                    word_sum.viol   <= viol_now;
                    word_sum.ordset <= comma0_now & ~viol_now;
                end else begin
                    pos        <= idx + PW'(1);
                    acc_viol   <= viol_now;
                    acc_comma0 <= comma0_now;
                end
            end
        end
    end

    // R2: a completed word needs several characters, so two never finish back to back
    a_r2_word_spacing: assert property (@(posedge clk) disable iff (rst)
        word_done |=> !word_done);

    // R2: a word only completes on an accepted character
    a_r2_done_needs_char: assert property (@(posedge clk) disable iff (rst)
        word_done |-> $past(chr_valid));

endmodule

// File: rtl/fcws_sync_fsm.sv
module fcws_sync_fsm
    import fcws_pkg::*;
#(
    parameter int ACQ_WORDS  = 3,
    parameter int VIOL_LIMIT = 4
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      en,
    input  logic      word_done,
    input  word_sum_t word_sum,
    output logic      word_sync,
    output logic      los
);
    localparam int CMAX = (ACQ_WORDS > VIOL_LIMIT) ? ACQ_WORDS : VIOL_LIMIT;
    localparam int CW   = $clog2(CMAX + 1);

    typedef struct packed {
        phase_e        phase;
        logic [CW-1:0] cnt;
        logic          half;
    } st_t;

    st_t st;
    st_t nx;

    always_comb begin
        nx = st;
        if (word_done) begin
            unique case (st.phase)
                PH_LOST, PH_ACQ: begin
                    if (word_sum.viol) begin
                        nx.phase = PH_LOST;
                        nx.cnt   = '0;
                        nx.half  = 1'b0;
                    end else if (word_sum.ordset) begin
                        if (st.cnt == CW'(ACQ_WORDS - 1)) begin
                            nx.phase = PH_LOCK;
                            nx.cnt   = '0;
                        end else begin
                            nx.phase = PH_ACQ;
                            nx.cnt   = st.cnt + CW'(1);
                        end
                        nx.half = 1'b0;
                    end
                end
                PH_LOCK: begin
                    if (word_sum.viol) begin
                        if (st.cnt == CW'(VIOL_LIMIT - 1)) begin
                            nx.phase = PH_LOST;
                            nx.cnt   = '0;
                        end else begin
                            nx.cnt = st.cnt + CW'(1);
                        end
                        nx.half = 1'b0;
                    end else if (st.cnt != '0) begin
                        if (st.half) begin
                            nx.cnt  = st.cnt - CW'(1);
                            nx.half = 1'b0;
                        end else begin
                            nx.half = 1'b1;
                        end
                    end
                end
                default: begin
                    nx.phase = PH_LOST;
                    nx.cnt   = '0;
                    nx.half  = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            st.phase <= PH_LOST;
            st.cnt   <= '0;
            st.half  <= 1'b0;
        end else begin
            st <= nx;
        end
    end

    assign word_sync = (st.phase == PH_LOCK);
    assign los       = (st.phase == PH_LOST);

    // R1: a cycle with the enable low leaves the lane lost
    a_r1_enable_forces_lost: assert property (@(posedge clk) disable iff (rst)
        !en |=> los);

    // R9: the two flags are exclusive
    a_r9_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(word_sync && los));

    // R10: without a completed word the state holds, unless forced lost
    a_r10_hold_between_words: assert property (@(posedge clk) disable iff (rst)
        !word_done |=> ($stable(st) || los));

    // R5: acquisition takes more than one word, never lost straight to locked
    a_r5_no_direct_lock: assert property (@(posedge clk) disable iff (rst)
        los |=> !word_sync);

    // R7: a violation at the last level drops the lane
    a_r7_last_violation_drops: assert property (@(posedge clk) disable iff (rst)
        (en && word_done && word_sum.viol && st.phase == PH_LOCK
         && st.cnt == CW'(VIOL_LIMIT - 1)) |=> los);

endmodule

// File: rtl/fcws_lane_sync.sv
module fcws_lane_sync
    import fcws_pkg::*;
#(
    parameter int WORD_CHARS = 4,
    parameter int ACQ_WORDS  = 3,
    parameter int VIOL_LIMIT = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic lsm_en,
    input  logic chr_valid,
    input  logic word_start,
    input  logic chr_comma,
    input  logic chr_cv,
    input  logic chr_rderr,
    output logic word_sync,
    output logic los
);
    chr_flags_t flags;
    logic       word_done;
    word_sum_t  word_sum;

    assign flags.comma = chr_comma;
    assign flags.cv    = chr_cv;
    assign flags.rderr = chr_rderr;

    fcws_word_collect #(
        .WORD_CHARS(WORD_CHARS)
    ) u_collect (
        .clk       (clk),
        .rst       (rst),
        .clr       (~lsm_en),
        .chr_valid (chr_valid),
        .word_start(word_start),
        .flags     (flags),
        .word_done (word_done),
        .word_sum  (word_sum)
    );

    fcws_sync_fsm #(
        .ACQ_WORDS (ACQ_WORDS),
        .VIOL_LIMIT(VIOL_LIMIT)
    ) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .en       (lsm_en),
        .word_done(word_done),
        .word_sum (word_sum),
        .word_sync(word_sync),
        .los      (los)
    );

endmodule

// File: tb/sim_fcws_lane_sync.sv
`timescale 1ns/1ps
module sim_fcws_lane_sync;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic lsm_en = 1'b1;
    logic chr_valid = 1'b0;
    logic word_start = 1'b0;
    logic chr_comma = 1'b0;
    logic chr_cv = 1'b0;
    logic chr_rderr = 1'b0;
    logic word_sync;
    logic los;

    int checks = 0;
    int errors = 0;

    // reference model state
    bit m_lock = 0;
    int m_acq  = 0;
    int m_lvl  = 0;
    bit m_good = 0;

    always #2 clk = ~clk;

    fcws_lane_sync u0 (
        .clk(clk), .rst(rst), .lsm_en(lsm_en), .chr_valid(chr_valid),
        .word_start(word_start), .chr_comma(chr_comma), .chr_cv(chr_cv),
        .chr_rderr(chr_rderr), .word_sync(word_sync), .los(los)
    );

    function automatic void model_clear();
        m_lock = 0; m_acq = 0; m_lvl = 0; m_good = 0;
    endfunction

    function automatic void model_word(input bit viol, input bit os);
        if (!m_lock) begin
            if (viol) m_acq = 0;
            else if (os) begin
                m_acq++;
                if (m_acq == 3) begin m_lock = 1; m_lvl = 0; m_good = 0; m_acq = 0; end
            end
        end else if (viol) begin
            if (m_lvl == 3) begin m_lock = 0; m_acq = 0; end
            else begin m_lvl++; m_good = 0; end
        end else if (m_lvl != 0) begin
            if (m_good) begin m_lvl--; m_good = 0; end
            else m_good = 1;
        end
    endfunction

    function automatic bit exp_los();
        return !m_lock && (m_acq == 0);
    endfunction

    task automatic check(input logic got, input logic exp, input string req, input string what);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %0b expected %0b", req, what, got, exp);
        end
    endtask

    task automatic check_both(input string req);
        check(word_sync, m_lock, req, "word_sync");
        check(los, exp_los(), req, "los");
    endtask

    task automatic idle_cycle();
        chr_valid  = 1'b0;
        word_start = $urandom_range(0, 1);
        chr_comma  = $urandom_range(0, 1);
        chr_cv     = $urandom_range(0, 1);
        chr_rderr  = $urandom_range(0, 1);
        @(negedge clk);
    endtask

    task automatic put_char(input bit ws, input bit cm, input bit cv, input bit rd);
        chr_valid = 1'b1; word_start = ws; chr_comma = cm; chr_cv = cv; chr_rderr = rd;
        @(negedge clk);
        chr_valid = 1'b0; word_start = 1'b0; chr_comma = 1'b0; chr_cv = 1'b0; chr_rderr = 1'b0;
    endtask

    // sends a word, updates the model; outputs are due one falling edge later
    task automatic send_word(input logic [3:0] cm, input logic [3:0] cv,
                             input logic [3:0] rd, input int max_gap);
        bit viol;
        bit os;
        for (int i = 0; i < 4; i++) begin
            if (max_gap > 0 && i > 0) begin
                int g = $urandom_range(0, max_gap);
                for (int k = 0; k < g; k++) idle_cycle();
            end
            put_char(i == 0, cm[i], cv[i], rd[i]);
        end
        viol = (|cv) || (|rd) || (|cm[3:1]);
        os   = cm[0] && !viol;
        model_word(viol, os);
    endtask

    task automatic word_check(input logic [3:0] cm, input logic [3:0] cv,
                              input logic [3:0] rd, input string req);
        send_word(cm, cv, rd, 0);
        @(negedge clk);
        check_both(req);
    endtask

    task automatic do_reset();
        rst = 1'b1; lsm_en = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        model_clear();
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        @(negedge clk);
        @(negedge clk);
        // R1 reset state
        check(los, 1'b1, "R1", "los in reset");
        check(word_sync, 1'b0, "R1", "word_sync in reset");
        do_reset();
        check_both("R1");

        // R5 acquisition with a valid data word in between (count held)
        word_check(4'b0001, 4'b0, 4'b0, "R5");
        check(los, 1'b0, "R5", "los after first ordered set");
        word_check(4'b0000, 4'b0, 4'b0, "R5");
        word_check(4'b0001, 4'b0, 4'b0, "R5");
        check(word_sync, 1'b0, "R5", "not yet locked after two");

        // R10 latency: third ordered set, check at intermediate edge
        send_word(4'b0001, 4'b0, 4'b0, 0);
        check(word_sync, 1'b0, "R10", "sync one edge after last char");
        @(negedge clk);
        check(word_sync, 1'b1, "R10", "sync two edges after last char");
        check_both("R9");

        // R8 recovery: violation, one valid, second valid
        word_check(4'b0000, 4'b0100, 4'b0, "R7");
        word_check(4'b0000, 4'b0, 4'b0, "R8");
        word_check(4'b0000, 4'b0, 4'b0, "R8");
        // R7 four unrecovered violations, each kind of violation from R3
        word_check(4'b0000, 4'b0, 4'b1000, "R3");
        word_check(4'b0011, 4'b0, 4'b0, "R3");
        word_check(4'b0000, 4'b0, 4'b0, "R8");
        word_check(4'b0000, 4'b0001, 4'b0, "R7");
        check(word_sync, 1'b1, "R9", "locked at level 3");
        word_check(4'b1000, 4'b0, 4'b0, "R7");
        check(los, 1'b1, "R7", "fourth violation drops lock");

        // R6 violation during acquisition restarts
        word_check(4'b0001, 4'b0, 4'b0, "R6");
        word_check(4'b0001, 4'b0, 4'b0, "R6");
        word_check(4'b0001, 4'b0010, 4'b0, "R6");
        check(los, 1'b1, "R6", "violation restarts acquisition");

        // R4 misplaced comma alone is not an ordered set
        word_check(4'b0100, 4'b0, 4'b0, "R4");

        // R2 abandoned partial word: comma-led start then restart with data
        put_char(1'b1, 1'b1, 1'b0, 1'b0);
        put_char(1'b0, 1'b0, 1'b0, 1'b0);
        word_check(4'b0000, 4'b0, 4'b0, "R2");
        check(los, 1'b1, "R2", "partial word discarded");

        // R1 enable drop while locked
        for (int i = 0; i < 3; i++) send_word(4'b0001, 4'b0, 4'b0, 0);
        @(negedge clk);
        check_both("R5");
        lsm_en = 1'b0;
        @(negedge clk);
        lsm_en = 1'b1;
        model_clear();
        check(los, 1'b1, "R1", "los after enable low");
        check(word_sync, 1'b0, "R1", "word_sync after enable low");

        // random words with random gaps (R2 idle cycles ignored)
        for (int n = 0; n < 900; n++) begin
            logic [3:0] cm = 4'b0;
            logic [3:0] cv = 4'b0;
            logic [3:0] rd = 4'b0;
            int kind = $urandom_range(0, 9);
            int p = $urandom_range(0, 3);
            if (kind <= 4) cm = 4'b0001;
            else if (kind == 7) cv[p] = 1'b1;
            else if (kind == 8) rd[p] = 1'b1;
            else if (kind == 9) begin
                cm[(p == 0) ? 1 : p] = 1'b1;
                cm[0] = $urandom_range(0, 1);
            end
            send_word(cm, cv, rd, 2);
            @(negedge clk);
            check_both("R2");
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule